// File: doc/BRIEF.md
# Register-Mapped Iterative Integer Divider

This block is a 32-bit integer divider attached to a simple processor register bus. Software writes a dividend and a divisor. Each operand write starts a new division, and the result is ready a fixed number of clock cycles later. Software polls a status register until the ready flag is set, then reads the quotient and the remainder. The dividend and the divisor each have two write addresses, one unsigned and one signed. The address written last sets whether the division is signed.

All four data registers can be written directly. Interrupt code can therefore save the unit's full state and restore it later. A dirty flag shows that the unit's state has been touched since its owner last read the quotient. Writing the quotient or the remainder stops any running division, so that division cannot overwrite the restored values.

The engine is a restoring divider. It resolves `BPC` quotient bits per clock cycle. With the default settings, 4 bits per cycle over 32 bits gives a latency of 8 cycles.

Top module: `mmio_divider`

## Requirements
- R1: An operand write is captured on a clock edge. The ready flag reads 0 after that edge and after each of the next 7 edges. It reads 1 after the 8th edge, and the quotient and remainder are final from then on.
- R2: The status register is at address 0x18. It holds ready in bit 0 and dirty in bit 1, and the other bits read 0. After reset it reads 0x1, and the quotient and remainder read 0.
- R3: A write to any operand address sets dirty and restarts the division. The restart uses the new value and the other operand register as it stands.
- R4: Reading the quotient (0x10) clears dirty. Reading the remainder (0x14) leaves dirty unchanged.
- R5: Writing the remainder (0x14) stores the written value and sets ready and dirty. Any running division is stopped, and the remainder keeps the written value.
- R6: Writing the quotient (0x10) stores the written value and sets ready and dirty. Any running division is stopped, and the quotient keeps the written value.
- R7: The addresses are 0x0 unsigned dividend, 0x4 unsigned divisor, 0x8 signed dividend and 0xC signed divisor. The division is signed only if the last operand write went to 0x8 or 0xC.
- R8: A zero divisor in unsigned mode gives a quotient of 0xFFFFFFFF. In signed mode it gives 1 for a non-negative dividend and 0xFFFFFFFF (-1) for a negative one. In both modes the remainder equals the dividend.
- R9: Signed division truncates the quotient toward zero, and the remainder takes the sign of the dividend. 0x80000000 divided by -1 gives a quotient of 0x80000000 and a remainder of 0.
- R10: The dividend reads back at 0x0 and at 0x8, and the divisor at 0x4 and at 0xC. Each returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe. Takes priority over a read in the same cycle |
| rd_en_i | input | 1 | Register read strobe. Only needed for the read side effect on dirty |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, a combinational function of addr_i |

## Verification
Once an operand write has been captured, the ready flag is due exactly 8 clock edges later. The bench samples the status register on the falling edge after each of those 8 edges and expects 0 seven times, then 1. Writes to the quotient or remainder and quotient reads take effect on the edge that captures them. The bench samples the flags on the next falling edge, and for aborts it samples again after more than 8 further edges. This second sample shows that the stopped division never writes back.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_A_U = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_B_U = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_A_S = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_B_S = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_QUO = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_REM = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_CSR = 5'h18;

  localparam int unsigned CSR_READY = 0;
  localparam int unsigned CSR_DIRTY = 1;
endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] rem_sh;
  logic       ge;

  always_comb begin
    rem_sh = {rem_i, quo_i[W-1]};
    ge     = rem_sh >= {1'b0, dvs_i};
    // difference is below 2^W whenever ge holds
    rem_o  = ge ? (rem_sh[W-1:0] - dvs_i) : rem_sh[W-1:0];
    quo_o  = {quo_i[W-2:0], ge};
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int unsigned W   = 32,
  parameter int unsigned BPC = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         quo_wr_i,
  input  logic         rem_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         busy_o
);
  localparam int unsigned STEPS = W / BPC;
  localparam int unsigned CW    = $clog2(STEPS + 1);

  logic [W-1:0]  quo_q, rem_q, dmag_q;
  logic          neg_q_q, neg_r_q, zsig_q;
  logic [CW-1:0] cnt_q;

  logic [W-1:0] r_ch [BPC+1];
  logic [W-1:0] q_ch [BPC+1];

  assign r_ch[0] = rem_q;
  assign q_ch[0] = quo_q;

  for (genvar g = 0; g < BPC; g++) begin : g_stage
    div_stage #(.W(W)) u_st (
      .rem_i(r_ch[g]),
      .quo_i(q_ch[g]),
      .dvs_i(dmag_q),
      .rem_o(r_ch[g+1]),
      .quo_o(q_ch[g+1])
    );
  end

  logic [W-1:0] a_mag, b_mag, q_fin, r_fin;
  logic         a_neg, b_neg;

  always_comb begin
    a_neg = signed_i && a_i[W-1];
    b_neg = signed_i && b_i[W-1];
    a_mag = a_neg ? -a_i : a_i;
    b_mag = b_neg ? -b_i : b_i;
    if (zsig_q)       q_fin = neg_r_q ? '1 : W'(1);
    else if (neg_q_q) q_fin = -q_ch[BPC];
    else              q_fin = q_ch[BPC];
    r_fin = neg_r_q ? -r_ch[BPC] : r_ch[BPC];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q   <= '0;
      rem_q   <= '0;
      dmag_q  <= '0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      zsig_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      quo_q   <= a_mag;
      rem_q   <= '0;
      dmag_q  <= b_mag;
      neg_q_q <= a_neg ^ b_neg;
      neg_r_q <= a_neg;
      zsig_q  <= signed_i && (b_i == '0);
      cnt_q   <= CW'(STEPS);
    end else if (quo_wr_i || rem_wr_i) begin
      if (quo_wr_i) quo_q <= wdata_i;
      if (rem_wr_i) rem_q <= wdata_i;
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      if (cnt_q == CW'(1)) begin
        quo_q <= q_fin;
        rem_q <= r_fin;
      end else begin
        quo_q <= q_ch[BPC];
        rem_q <= r_ch[BPC];
      end
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign busy_o = cnt_q != '0;
endmodule

// File: rtl/mmio_divider.sv
module mmio_divider
  import div_pkg::*;
#(
  parameter int unsigned BPC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned W = DATA_W;

  logic [W-1:0] a_q, b_q, quo_w, rem_w;
  logic         sgn_q, dirty_q, ready_w, busy_w;
  logic         a_sel, b_sel, op_wr, quo_wr, rem_wr, sgn_sel;

  always_comb begin
    a_sel   = (addr_i == OFF_A_U) || (addr_i == OFF_A_S);
    b_sel   = (addr_i == OFF_B_U) || (addr_i == OFF_B_S);
    sgn_sel = (addr_i == OFF_A_S) || (addr_i == OFF_B_S);
    op_wr   = wr_en_i && (a_sel || b_sel);
    quo_wr  = wr_en_i && (addr_i == OFF_QUO);
    rem_wr  = wr_en_i && (addr_i == OFF_REM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      sgn_q   <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      if (op_wr) begin
        sgn_q <= sgn_sel;
        if (a_sel) a_q <= wdata_i;
        if (b_sel) b_q <= wdata_i;
      end
      if (op_wr || quo_wr || rem_wr)
        dirty_q <= 1'b1;
      else if (rd_en_i && !wr_en_i && addr_i == OFF_QUO)
        dirty_q <= 1'b0;
    end
  end

  div_core #(.W(W), .BPC(BPC)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (op_wr),
    .signed_i (sgn_sel),
    .a_i      (a_sel ? wdata_i : a_q),
    .b_i      (b_sel ? wdata_i : b_q),
    .quo_wr_i (quo_wr),
    .rem_wr_i (rem_wr),
    .wdata_i  (wdata_i),
    .quo_o    (quo_w),
    .rem_o    (rem_w),
    .busy_o   (busy_w)
  );

  assign ready_w = !busy_w;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_A_U, OFF_A_S: rdata_o = a_q;
      OFF_B_U, OFF_B_S: rdata_o = b_q;
      OFF_QUO:          rdata_o = quo_w;
      OFF_REM:          rdata_o = rem_w;
      OFF_CSR: begin
        rdata_o[CSR_READY] = ready_w;
        rdata_o[CSR_DIRTY] = dirty_q;
      end
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/div_chk.sv
module div_chk
  import div_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned STEPS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      rdata_o,
  input logic              ready,
  input logic              dirty,
  input logic [W-1:0]      quo,
  input logic [W-1:0]      rem
);
  localparam int unsigned LW = $clog2(STEPS + 2) + 1;

  logic          op_wr, res_wr;
  logic [LW-1:0] since_q;

  assign op_wr  = wr_en_i && (addr_i == OFF_A_U || addr_i == OFF_A_S ||
                              addr_i == OFF_B_U || addr_i == OFF_B_S);
  assign res_wr = wr_en_i && (addr_i == OFF_QUO || addr_i == OFF_REM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     since_q <= '1;
    else if (op_wr)                  since_q <= '0;
    else if (since_q != '1)          since_q <= since_q + LW'(1);
  end

  p_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready) && !$past(res_wr) |-> since_q == LW'(STEPS));

  p_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_wr |=> !ready);

  p_csr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFF_CSR |-> rdata_o[W-1:2] == '0 &&
      rdata_o[CSR_READY] == ready && rdata_o[CSR_DIRTY] == dirty);

  p_oper_dirty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_wr |=> dirty);

  p_qread_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i && addr_i == OFF_QUO |=> !dirty);

  p_rem_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == OFF_REM |=> ready && dirty && rem == $past(wdata_i));

  p_quo_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == OFF_QUO |=> ready && dirty && quo == $past(wdata_i));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready && !wr_en_i |=> $stable(quo) && $stable(rem));
endmodule

bind mmio_divider div_chk #(.W(W), .STEPS(W / BPC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .ready   (ready_w),
  .dirty   (dirty_q),
  .quo     (quo_w),
  .rem     (rem_w)
);

// File: tb/sim_mmio_divider.sv
`timescale 1ns/1ps
module sim_mmio_divider;
  import div_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  addr_i = OFF_CSR;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  mmio_divider u0 (.*);

  typedef struct packed {
    logic        s;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] q;
    logic [31:0] r;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd100,        32'd7,          32'd14,         32'd2},
    '{1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0},
    '{1'b0, 32'h80000000,   32'd3,          32'h2AAAAAAA,   32'd2},
    '{1'b0, 32'd5,          32'd0,          32'hFFFFFFFF,   32'd5},
    '{1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   32'hFFFFFFFF},
    '{1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD,   32'd1},
    '{1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3,          32'hFFFFFFFF},
    '{1'b1, 32'hFFFFFFF7,   32'd0,          32'hFFFFFFFF,   32'hFFFFFFF7},
    '{1'b1, 32'd9,          32'd0,          32'd1,          32'd9},
    '{1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   32'd0},
    '{1'b0, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC,   32'd1}
  };

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = OFF_CSR;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_en_i = 1'b0; addr_i = OFF_CSR;
  endtask

  task automatic peek(logic [4:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    // reset state
    peek(OFF_CSR, d); chk("R2 reset csr", d, 32'h1);
    peek(OFF_QUO, d); chk("R2 reset quo", d, 32'h0);
    peek(OFF_REM, d); chk("R2 reset rem", d, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    peek(OFF_CSR, d); chk("R2 csr after release", d, 32'h1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      bus_wr(VECS[i].s ? OFF_A_S : OFF_A_U, VECS[i].a);
      bus_wr(VECS[i].s ? OFF_B_S : OFF_B_U, VECS[i].b);
      edges(7);
      bus_rd(OFF_QUO, d); chk($sformatf("R7 R8 R9 quo vec%0d", i), d, VECS[i].q);
      bus_rd(OFF_REM, d); chk($sformatf("R7 R8 R9 rem vec%0d", i), d, VECS[i].r);
    end

    // R1 latency, R3 dirty set, R10 readback
    bus_wr(OFF_A_U, 32'd1000);
    peek(OFF_CSR, d); chk("R3 dirty after dividend write", d, 32'h2);
    bus_wr(OFF_B_S, 32'd9);
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      peek(OFF_CSR, d);
      chk($sformatf("R1 ready after edge %0d", k), {31'b0, d[0]}, (k >= 8) ? 32'h1 : 32'h0);
    end
    peek(OFF_QUO, d); chk("R3 quo uses new divisor", d, 32'd111);
    peek(OFF_A_S, d); chk("R10 dividend at signed alias", d, 32'd1000);
    peek(OFF_B_U, d); chk("R10 divisor at unsigned alias", d, 32'd9);

    // R4 remainder read keeps dirty, quotient read clears it
    bus_rd(OFF_REM, d); chk("R4 rem value", d, 32'd1);
    peek(OFF_CSR, d); chk("R4 dirty kept after rem read", d, 32'h3);
    bus_rd(OFF_QUO, d);
    peek(OFF_CSR, d); chk("R4 dirty cleared by quo read", d, 32'h1);

    // R5 remainder write aborts a running division
    bus_wr(OFF_A_U, 32'd50);
    bus_wr(OFF_B_U, 32'd3);
    edges(2);
    bus_rd(OFF_QUO, d);
    bus_wr(OFF_REM, 32'h00001234);
    peek(OFF_CSR, d); chk("R5 csr after rem write", d, 32'h3);
    edges(10);
    peek(OFF_REM, d); chk("R5 rem kept after abort", d, 32'h00001234);
    peek(OFF_CSR, d); chk("R5 csr later", d, 32'h3);

    // R6 quotient write aborts a running division
    bus_wr(OFF_B_U, 32'd7);
    edges(2);
    bus_rd(OFF_QUO, d);
    bus_wr(OFF_QUO, 32'hCAFE0001);
    peek(OFF_CSR, d); chk("R6 csr after quo write", d, 32'h3);
    edges(10);
    peek(OFF_QUO, d); chk("R6 quo kept after abort", d, 32'hCAFE0001);

    // R7 signedness follows last alias: signed dividend then unsigned divisor
    bus_wr(OFF_A_S, 32'hFFFFFFF9);
    bus_wr(OFF_B_U, 32'd2);
    edges(8);
    peek(OFF_QUO, d); chk("R7 unsigned after mixed aliases", d, 32'h7FFFFFFC);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule